// File: doc/BRIEF.md
# Display Scan-Direction and Window Command Sequencer

This block turns two kinds of high-level display requests into the command/data byte stream that a small panel controller expects. A rotation request takes a two-bit angle code and a blue/red order flag and produces the address-mode command with its single argument byte. A window request takes a drawing rectangle (first and last column, first and last row) and produces the column-range command, the row-range command and finally the opcode that opens frame memory for writing. The pixel bytes that follow are sent by other logic.

Bytes leave on a valid/ready stream with a flag that marks each byte as command or data. Requests are taken only while the block is idle, and their arguments are captured at that moment. A one-cycle done pulse marks the end of each update. Coordinates are always 8 bits wide because the panel is 176 by 220 pixels. Each is sent as a 16-bit value whose high byte is zero. Range checking of coordinates is left to the requester.

Top module: `win_rot_cmdr`

## Requirements
- R1: After reset, `cmd_valid` and `upd_done` are low.
- R2: A rotation update sends two bytes: opcode 36h with `cmd_is_data`=0, then the mode byte with `cmd_is_data`=1.
- R3: The mode byte sets bit 7 (row order swap), bit 6 (column order swap) and bit 5 (row/column exchange) by angle code: 0 sets none, 1 (90°) sets bits 7 and 5, 2 (180°) sets bits 7 and 6, 3 (270°) sets bits 6 and 5. Bits 4 and 2..0 are always zero.
- R4: Bit 3 of the mode byte equals the `rot_bgr` value captured with the request.
- R5: A window update sends 11 bytes in this order: 2Ah (command), 00h, x-first, 00h, x-last, 2Bh (command), 00h, y-first, 00h, y-last, then 2Ch (command). All bytes between the opcodes are data.
- R6: While `cmd_valid` is high and `cmd_ready` is low, the byte and its command/data flag stay unchanged and `cmd_valid` stays high.
- R7: A request is accepted only in a cycle where `cmd_valid` is low. Requests raised while a stream is in progress are dropped and produce no bytes.
- R8: When both requests are accepted in the same idle cycle, the two rotation bytes go out first and the 11 window bytes follow them with no gap.
- R9: `upd_done` is high for exactly the one cycle after the last byte of each update is accepted. A combined request therefore gives two pulses.
- R10: Arguments are sampled in the accepting cycle. Later changes on the argument inputs do not alter the bytes of that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rot_req | input | 1 | Request a scan-direction update |
| rot_angle | input | 2 | Angle code: 0=0°, 1=90°, 2=180°, 3=270° |
| rot_bgr | input | 1 | Blue/red order flag for mode bit 3 |
| win_req | input | 1 | Request a drawing-window update |
| win_x0 | input | 8 | First column |
| win_x1 | input | 8 | Last column |
| win_y0 | input | 8 | First row |
| win_y1 | input | 8 | Last row |
| cmd_valid | output | 1 | Output byte is valid |
| cmd_ready | input | 1 | Downstream accepts the byte |
| cmd_is_data | output | 1 | 0 = command byte, 1 = data byte |
| cmd_byte | output | 8 | Output byte |
| upd_done | output | 1 | One-cycle pulse at the end of each update |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the two request types. The bench raises rotation and window requests together in idle cycles, at random and in a directed case. The reference model expects 13 bytes with the rotation pair at the front, and it expects a done pulse in the middle of the stream. The second pair is the end of one update and a new request. The bench holds requests high through the cycle in which the last byte is accepted. The model expects them to be dropped in that cycle and a request raised afterwards to be taken only once `cmd_valid` has fallen. The bench compares output valid, byte, flag and done against the model at every clock while `cmd_ready` is toggled at random.

// File: rtl/win_rot_cmdr.sv
module win_rot_cmdr #(
  parameter int          BYTE_W  = 8,
  parameter logic [7:0]  OP_MODE = 8'h36,
  parameter logic [7:0]  OP_COL  = 8'h2A,
  parameter logic [7:0]  OP_ROW  = 8'h2B,
  parameter logic [7:0]  OP_MEMW = 8'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rot_req,
  input  logic [1:0]        rot_angle,
  input  logic              rot_bgr,
  input  logic              win_req,
  input  logic [BYTE_W-1:0] win_x0,
  input  logic [BYTE_W-1:0] win_x1,
  input  logic [BYTE_W-1:0] win_y0,
  input  logic [BYTE_W-1:0] win_y1,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_is_data,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              upd_done
);
  localparam int IW       = 4;
  localparam logic [IW-1:0] ROT_FIRST = 4'd0;
  localparam logic [IW-1:0] ROT_LAST  = 4'd1;
  localparam logic [IW-1:0] WIN_FIRST = 4'd2;
  localparam logic [IW-1:0] WIN_LAST  = 4'd12;

  logic [IW-1:0]     slot;
  logic              pend_rot, pend_win;
  logic [1:0]        angle_q;
  logic              bgr_q;
  logic [BYTE_W-1:0] x0_q, x1_q, y0_q, y1_q;
  logic [BYTE_W-1:0] mode_byte;

  wire busy = pend_rot | pend_win;
  wire fire = cmd_valid & cmd_ready;

  assign cmd_valid = busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot     <= '0;
      pend_rot <= 1'b0;
      pend_win <= 1'b0;
      upd_done <= 1'b0;
      angle_q  <= '0;
      bgr_q    <= 1'b0;
      x0_q     <= '0;
      x1_q     <= '0;
      y0_q     <= '0;
      y1_q     <= '0;
    end else begin
      upd_done <= 1'b0;
      if (!busy) begin
        if (rot_req) begin
          pend_rot <= 1'b1;
          angle_q  <= rot_angle;
          bgr_q    <= rot_bgr;
        end
        if (win_req) begin
          pend_win <= 1'b1;
          x0_q     <= win_x0;
          x1_q     <= win_x1;
          y0_q     <= win_y0;
          y1_q     <= win_y1;
        end
        slot <= rot_req ? ROT_FIRST : WIN_FIRST;
      end else if (fire) begin
        if (slot == ROT_LAST) begin
          pend_rot <= 1'b0;
          upd_done <= 1'b1;
          slot     <= WIN_FIRST;
        end else if (slot == WIN_LAST) begin
          pend_win <= 1'b0;
          upd_done <= 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  always_comb begin
    mode_byte = '0;
    case (angle_q)
      2'd1:    mode_byte[7:5] = 3'b101;
      2'd2:    mode_byte[7:5] = 3'b110;
      2'd3:    mode_byte[7:5] = 3'b011;
      default: mode_byte[7:5] = 3'b000;
    endcase
    mode_byte[3] = bgr_q;
  end

  always_comb begin
    cmd_is_data = 1'b1;
    cmd_byte    = '0;
    case (slot)
      4'd0:  begin cmd_is_data = 1'b0; cmd_byte = OP_MODE; end
      4'd1:  cmd_byte = mode_byte;
      4'd2:  begin cmd_is_data = 1'b0; cmd_byte = OP_COL; end
      4'd4:  cmd_byte = x0_q;
      4'd6:  cmd_byte = x1_q;
      4'd7:  begin cmd_is_data = 1'b0; cmd_byte = OP_ROW; end
      4'd9:  cmd_byte = y0_q;
      4'd11: cmd_byte = y1_q;
      4'd12: begin cmd_is_data = 1'b0; cmd_byte = OP_MEMW; end
      default: cmd_byte = '0;
    endcase
  end
endmodule

// File: rtl/win_rot_cmdr_chk.sv
module win_rot_cmdr_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rot_req,
  input logic [1:0]        rot_angle,
  input logic              rot_bgr,
  input logic              win_req,
  input logic [BYTE_W-1:0] win_x0,
  input logic [BYTE_W-1:0] win_x1,
  input logic [BYTE_W-1:0] win_y0,
  input logic [BYTE_W-1:0] win_y1,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_is_data,
  input logic [BYTE_W-1:0] cmd_byte,
  input logic              upd_done
);
  a_r6_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_byte) && $stable(cmd_is_data)));

  a_r9_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(cmd_valid && cmd_ready));

  a_r9_done_after_memw: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_is_data && cmd_byte == 8'h2C) |=> upd_done);

  a_r3_mode_byte_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_is_data && cmd_byte == 8'h36)
      |=> (cmd_valid && cmd_is_data && cmd_byte[4] == 1'b0 && cmd_byte[2:0] == 3'b000
           && $countones(cmd_byte[7:5]) != 3 && $countones(cmd_byte[7:5]) != 1));

  a_r2_mode_done: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_is_data && cmd_byte == 8'h36) |=> !upd_done);

  a_r1_no_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !$past(cmd_valid)) |-> !upd_done);
endmodule

bind win_rot_cmdr win_rot_cmdr_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/win_rot_cmdr_bench.sv
module win_rot_cmdr_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rot_req = 1'b0, rot_bgr = 1'b0, win_req = 1'b0, cmd_ready = 1'b0;
  logic [1:0] rot_angle = '0;
  logic [7:0] win_x0 = '0, win_x1 = '0, win_y0 = '0, win_y1 = '0;
  logic cmd_valid, cmd_is_data, upd_done;
  logic [7:0] cmd_byte;

  always #4 clk = ~clk;

  win_rot_cmdr u_win_rot_cmdr (.*);

  typedef struct { logic dc; logic [7:0] b; bit last; string tag; } item_t;
  item_t q[$];
  bit exp_done = 0;
  int checks = 0, errors = 0;
  bit run_done = 0;

  function automatic logic [7:0] mode_of(logic [1:0] a, logic bgr);
    logic [7:0] m;
    case (a)
      2'd0: m = 8'h00;
      2'd1: m = 8'hA0;
      2'd2: m = 8'hC0;
      default: m = 8'h60;
    endcase
    return m | (bgr ? 8'h08 : 8'h00);
  endfunction

  function automatic void push(logic dc, logic [7:0] b, bit last, string tag);
    item_t it;
    it.dc = dc; it.b = b; it.last = last; it.tag = tag;
    q.push_back(it);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      exp_done <= 0;
    end else begin
      exp_done <= 0;
      if (q.size() == 0) begin
        string t;
        t = (rot_req && win_req) ? "R8" : "";
        if (rot_req) begin
          push(1'b0, 8'h36, 0, {"R2 ", t});
          push(1'b1, mode_of(rot_angle, rot_bgr), 1, {"R3 R4 ", t});
        end
        if (win_req) begin
          push(1'b0, 8'h2A, 0, {"R5 ", t}); push(1'b1, 8'h00, 0, "R5");
          push(1'b1, win_x0, 0, "R5 R10"); push(1'b1, 8'h00, 0, "R5");
          push(1'b1, win_x1, 0, "R5 R10");
          push(1'b0, 8'h2B, 0, "R5"); push(1'b1, 8'h00, 0, "R5");
          push(1'b1, win_y0, 0, "R5 R10"); push(1'b1, 8'h00, 0, "R5");
          push(1'b1, win_y1, 0, "R5 R10");
          push(1'b0, 8'h2C, 1, "R5");
        end
      end else if (cmd_ready) begin
        if (q[0].last) exp_done <= 1;
        void'(q.pop_front());
      end
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !run_done) begin
      check(cmd_valid == (q.size() > 0), "R1 R7", "valid", cmd_valid, q.size() > 0);
      check(upd_done == exp_done, "R9", "done", upd_done, exp_done);
      if (cmd_valid && q.size() > 0) begin
        check(cmd_byte == q[0].b, {q[0].tag, " R6"}, "byte", cmd_byte, q[0].b);
        check(cmd_is_data == q[0].dc, {q[0].tag, " R6"}, "dc", cmd_is_data, q[0].dc);
      end
    end
  end

  initial begin
    #200000;
    if (!run_done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_valid !== 1'b0 || upd_done !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%0b%0b expected=00", cmd_valid, upd_done);
    end
    rst_n = 1'b1;
    // R8: both requests in one idle cycle, ready always high
    @(negedge clk);
    cmd_ready = 1; rot_req = 1; win_req = 1; rot_angle = 2'd1; rot_bgr = 1;
    win_x0 = 8'h05; win_x1 = 8'hAF; win_y0 = 8'h10; win_y1 = 8'hDB;
    @(negedge clk);
    // R7 and R10: requests and arguments keep changing while busy
    rot_angle = 2'd3; win_x0 = 8'h77;
    repeat (20) @(negedge clk);
    rot_req = 0; win_req = 0;
    repeat (3) @(negedge clk);
    // R3: every angle with ready stalls
    for (int a = 0; a < 4; a++) begin
      rot_req = 1; rot_angle = a[1:0]; rot_bgr = a[0];
      @(negedge clk);
      rot_req = 0; cmd_ready = 0;
      repeat (3) @(negedge clk);
      cmd_ready = 1;
      repeat (3) @(negedge clk);
    end
    // random phase
    for (int i = 0; i < 4000; i++) begin
      cmd_ready = ($urandom_range(0, 9) < 7);
      rot_req   = ($urandom_range(0, 3) == 0);
      win_req   = ($urandom_range(0, 3) == 0);
      rot_angle = 2'($urandom_range(0, 3));
      rot_bgr   = 1'($urandom_range(0, 1));
      win_x0 = 8'($urandom_range(0, 175)); win_x1 = 8'($urandom_range(0, 175));
      win_y0 = 8'($urandom_range(0, 219)); win_y1 = 8'($urandom_range(0, 219));
      @(negedge clk);
    end
    rot_req = 0; win_req = 0; cmd_ready = 1;
    repeat (20) @(negedge clk);
    run_done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule